// File: doc/BRIEF.md
# Extended control register read unit

This block serves the read of an extended processor control register in a simple CPU execution stage. It holds two pieces of state: a primary 64-bit extended control register and a 64-bit in-use state bitmap. A request carries a 64-bit index operand along with four qualifiers: a LOCK-prefix flag, a flag saying the feature is supported, an OS-enable control bit, and a capability bit for the in-use read variant.

A permitted request returns the selected 64-bit value split across two 64-bit destination registers, with the upper halves of both destinations cleared. A request that is not permitted produces an invalid-opcode fault or a general-protection fault instead, and neither destination changes.

Two simple synchronous write ports load the primary register and the bitmap. They exist so the block can be tested. Delivery of faults and instruction decode are handled outside the block.

Top module: `xcr_read_unit`

## Requirements
- R1: Only bits [31:0] of `req_index` select the register. Bits [63:32] have no effect on the fault or on the result.
- R2: The selected 64-bit value is split as follows. Bits [63:32] go to `dest_hi[31:0]` and bits [31:0] go to `dest_lo[31:0]`.
- R3: Whenever `done` is 1, `dest_hi[63:32]` and `dest_lo[63:32]` are zero.
- R4: Index 0 on a permitted request returns the primary register.
- R5: Index 1 with `inuse_cap` = 1 returns the bitwise AND of the primary register and the in-use bitmap.
- R6: The following requests set `fault` to 2 (general protection, error code 0):
  - index 1 with `inuse_cap` = 0;
  - any index other than 0 or 1.
- R7: Any of `feat_supported` = 0, `os_enable` = 0 or `req_lock` = 1 sets `fault` to 1 (invalid opcode). This check takes priority over R6.
- R8: On any fault, `dest_hi` and `dest_lo` keep their previous values.
- R9: Timing of the outputs:
  - `done` is 1 in the cycle after a cycle with `req_valid` = 1, and 0 otherwise.
  - `fault` is 0 whenever `done` is 0.
- R10: Primary register bits outside parameter `IMPL_MASK` (default 64'h0000_0003_0000_02FF) always read as zero.
- R11: Reset, which is synchronous and active-high, has these effects:
  - the primary register becomes 1;
  - the bitmap becomes 0;
  - `done`, `fault`, `dest_hi` and `dest_lo` become 0.
- R12: A request reads the state held before any test write in the same cycle. Such a write is visible to requests from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | One-cycle request pulse |
| req_index | input | 64 | Index operand; only bits [31:0] are used |
| req_lock | input | 1 | LOCK prefix present |
| feat_supported | input | 1 | Feature supported flag |
| os_enable | input | 1 | OS-enable control bit |
| inuse_cap | input | 1 | Capability bit for the index-1 in-use read |
| prim_wr_en | input | 1 | Test write enable, primary register |
| prim_wr_data | input | 64 | Test write data, primary register |
| map_wr_en | input | 1 | Test write enable, in-use bitmap |
| map_wr_data | input | 64 | Test write data, in-use bitmap |
| done | output | 1 | Result or fault valid |
| fault | output | 2 | 0 none, 1 invalid opcode, 2 general protection |
| dest_hi | output | 64 | High destination register |
| dest_lo | output | 64 | Low destination register |

## Verification
The hardest case to reach is an index-1 read issued in the same cycle as a bitmap or primary write. In that case the result must reflect the old AND, not the new one. Random stimulus lets both write ports fire alongside requests, so this collision occurs often. The bench's reference model commits its writes only after it computes the expected value. Directed cases add the remaining corners:
- a fault that follows a good result, which checks that the destinations hold;
- indices with non-zero upper bits;
- an all-ones primary write, which exposes the implemented-bit mask.

// File: rtl/xcr_rd_pkg.sv
package xcr_rd_pkg;
  localparam int unsigned IDX_W  = 64;
  localparam int unsigned DATA_W = 64;
  localparam int unsigned SEL_W  = 32;

  localparam logic [SEL_W-1:0] SEL_PRIMARY = 32'd0;
  localparam logic [SEL_W-1:0] SEL_INUSE   = 32'd1;

  typedef enum logic [1:0] {
    FLT_NONE = 2'd0,
    FLT_UD   = 2'd1,
    FLT_GP   = 2'd2
  } flt_e;
endpackage

// File: rtl/xcr_state_regs.sv
module xcr_state_regs #(
  parameter int unsigned     DATA_W    = 64,
  parameter logic [DATA_W-1:0] IMPL_MASK = 64'h0000_0003_0000_02FF,
  parameter logic [DATA_W-1:0] PRIM_RST  = 64'h1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              prim_we,
  input  logic [DATA_W-1:0] prim_wd,
  input  logic              map_we,
  input  logic [DATA_W-1:0] map_wd,
  output logic [DATA_W-1:0] prim_q,
  output logic [DATA_W-1:0] map_q
);
  localparam logic [DATA_W-1:0] PRIM_RST_M = PRIM_RST & IMPL_MASK;

  // Primary register: unimplemented bits never store anything.
  always_ff @(posedge clk) begin
    if (rst) begin
      prim_q <= PRIM_RST_M;
    end else if (prim_we) begin
      prim_q <= prim_wd & IMPL_MASK;
    end
  end

  // In-use bitmap: full width.
  always_ff @(posedge clk) begin
    if (rst) begin
      map_q <= '0;
    end else if (map_we) begin
      map_q <= map_wd;
    end
  end

  AST_PRIM_MASKED: assert property (@(posedge clk) disable iff (rst)
    $past(prim_we) |-> ((prim_q & ~IMPL_MASK) == '0)); // R10

  AST_MAP_KEEP: assert property (@(posedge clk) disable iff (rst)
    !$past(map_we) && !$past(rst) |-> $stable(map_q)); // R12
endmodule

// File: rtl/xcr_fault_check.sv
module xcr_fault_check
  import xcr_rd_pkg::*;
(
  input  logic [SEL_W-1:0] sel,
  input  logic             lock_pfx,
  input  logic             feat_ok,
  input  logic             os_en,
  input  logic             cap_inuse,
  output flt_e             flt,
  output logic             use_inuse
);
  logic ud_hit;
  logic sel_prim;
  logic sel_map_ok;

  assign ud_hit     = !feat_ok || !os_en || lock_pfx;
  assign sel_prim   = (sel == SEL_PRIMARY);
  assign sel_map_ok = (sel == SEL_INUSE) && cap_inuse;
  assign use_inuse  = (sel == SEL_INUSE);

  // Invalid opcode outranks general protection.
  always_comb begin
    if (ud_hit) begin
      flt = FLT_UD;
    end else if (sel_prim || sel_map_ok) begin
      flt = FLT_NONE;
    end else begin
      flt = FLT_GP;
    end
  end
endmodule

// File: rtl/xcr_result_fmt.sv
module xcr_result_fmt #(
  parameter int unsigned DATA_W = 64
) (
  input  logic              use_inuse,
  input  logic [DATA_W-1:0] prim,
  input  logic [DATA_W-1:0] inuse_map,
  output logic [DATA_W-1:0] res_hi,
  output logic [DATA_W-1:0] res_lo
);
  localparam int unsigned HALF = DATA_W / 2;

  logic [DATA_W-1:0] value;

  generate
    for (genvar b = 0; b < DATA_W; b++) begin : g_bit
      assign value[b] = use_inuse ? (prim[b] & inuse_map[b]) : prim[b];
    end
  endgenerate

  // Each half lands in the low half of its destination; upper halves are cleared.
  assign res_hi = {{(DATA_W-HALF){1'b0}}, value[DATA_W-1:HALF]};
  assign res_lo = {{(DATA_W-HALF){1'b0}}, value[HALF-1:0]};
endmodule

// File: rtl/xcr_read_unit.sv
module xcr_read_unit
  import xcr_rd_pkg::*;
#(
  parameter logic [63:0] IMPL_MASK = 64'h0000_0003_0000_02FF,
  parameter logic [63:0] PRIM_RST  = 64'h1
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        req_valid,
  input  logic [63:0] req_index,
  input  logic        req_lock,
  input  logic        feat_supported,
  input  logic        os_enable,
  input  logic        inuse_cap,
  input  logic        prim_wr_en,
  input  logic [63:0] prim_wr_data,
  input  logic        map_wr_en,
  input  logic [63:0] map_wr_data,
  output logic        done,
  output logic [1:0]  fault,
  output logic [63:0] dest_hi,
  output logic [63:0] dest_lo
);
  localparam int unsigned HALF = DATA_W / 2;

  logic [DATA_W-1:0] prim_q;
  logic [DATA_W-1:0] map_q;
  flt_e              flt_c;
  logic              use_inuse;
  logic [DATA_W-1:0] res_hi;
  logic [DATA_W-1:0] res_lo;

  xcr_state_regs #(
    .DATA_W   (DATA_W),
    .IMPL_MASK(IMPL_MASK),
    .PRIM_RST (PRIM_RST)
  ) u_state (
    .clk    (clk),
    .rst    (rst),
    .prim_we(prim_wr_en),
    .prim_wd(prim_wr_data),
    .map_we (map_wr_en),
    .map_wd (map_wr_data),
    .prim_q (prim_q),
    .map_q  (map_q)
  );

  xcr_fault_check u_fchk (
    .sel      (req_index[SEL_W-1:0]),
    .lock_pfx (req_lock),
    .feat_ok  (feat_supported),
    .os_en    (os_enable),
    .cap_inuse(inuse_cap),
    .flt      (flt_c),
    .use_inuse(use_inuse)
  );

  xcr_result_fmt #(.DATA_W(DATA_W)) u_fmt (
    .use_inuse(use_inuse),
    .prim     (prim_q),
    .inuse_map(map_q),
    .res_hi   (res_hi),
    .res_lo   (res_lo)
  );

  // Completion and fault code: registered, valid for one cycle.
  always_ff @(posedge clk) begin
    if (rst) begin
      done  <= 1'b0;
      fault <= FLT_NONE;
    end else begin
      done  <= req_valid;
      fault <= req_valid ? flt_c : FLT_NONE;
    end
  end

  // Destinations: written only by a permitted request.
  always_ff @(posedge clk) begin
    if (rst) begin
      dest_hi <= '0;
      dest_lo <= '0;
    end else if (req_valid && (flt_c == FLT_NONE)) begin
      dest_hi <= res_hi;
      dest_lo <= res_lo;
    end
  end

  AST_UPPER_CLEAR: assert property (@(posedge clk) disable iff (rst)
    done |-> (dest_hi[63:HALF] == '0) && (dest_lo[63:HALF] == '0)); // R3

  AST_FAULT_HOLDS: assert property (@(posedge clk) disable iff (rst)
    done && (fault != FLT_NONE) |-> $stable(dest_hi) && $stable(dest_lo)); // R8

  AST_DONE_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> done); // R9

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !done |-> (fault == FLT_NONE)); // R9

  AST_UD_FIRST: assert property (@(posedge clk) disable iff (rst)
    req_valid && (!feat_supported || !os_enable || req_lock) |=> fault == FLT_UD); // R7

  AST_IDX0_VALUE: assert property (@(posedge clk) disable iff (rst)
    req_valid && feat_supported && os_enable && !req_lock && (req_index[31:0] == 32'd0)
    |=> {dest_hi[HALF-1:0], dest_lo[HALF-1:0]} == $past(prim_q)); // R4
endmodule

// File: tb/test_xcr_read_unit.sv
module test_xcr_read_unit;
  localparam logic [63:0] MASK = 64'h0000_0003_0000_02FF;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [63:0] req_index = '0;
  logic        req_lock = 1'b0;
  logic        feat_supported = 1'b1;
  logic        os_enable = 1'b1;
  logic        inuse_cap = 1'b1;
  logic        prim_wr_en = 1'b0;
  logic [63:0] prim_wr_data = '0;
  logic        map_wr_en = 1'b0;
  logic [63:0] map_wr_data = '0;
  logic        done;
  logic [1:0]  fault;
  logic [63:0] dest_hi;
  logic [63:0] dest_lo;

  int compared = 0;
  int mismatched = 0;
  bit finished = 1'b0;

  logic [63:0] mprim, mmap;
  logic        e_done;
  logic [1:0]  e_fault;
  logic [63:0] e_hi, e_lo;
  string       e_tag, f_tag;

  always #4 clk = ~clk;

  xcr_read_unit i_xcr_read_unit (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_index(req_index),
    .req_lock(req_lock), .feat_supported(feat_supported), .os_enable(os_enable),
    .inuse_cap(inuse_cap), .prim_wr_en(prim_wr_en), .prim_wr_data(prim_wr_data),
    .map_wr_en(map_wr_en), .map_wr_data(map_wr_data), .done(done), .fault(fault),
    .dest_hi(dest_hi), .dest_lo(dest_lo)
  );

  function automatic logic [1:0] ref_fault(logic [63:0] idx, logic lk, logic ft, logic os, logic cp);
    if (!ft || !os || lk) return 2'd1;
    if (idx[31:0] == 32'd0) return 2'd0;
    if (idx[31:0] == 32'd1 && cp) return 2'd0;
    return 2'd2;
  endfunction

  function automatic logic [63:0] ref_value(logic [63:0] idx, logic [63:0] p, logic [63:0] m);
    return (idx[31:0] == 32'd0) ? p : (p & m);
  endfunction

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic check_pending();
    check("R9 done", {63'd0, done}, {63'd0, e_done});
    check({f_tag, " fault"}, {62'd0, fault}, {62'd0, e_fault});
    check({e_tag, " dest_hi"}, dest_hi, e_hi);
    check({e_tag, " dest_lo"}, dest_lo, e_lo);
    if (done) check("R3 upper halves", {dest_hi[63:32], dest_lo[63:32]}, 64'd0);
  endtask

  // One cycle: check last result at the negedge, then drive the next inputs.
  task automatic step(logic v, logic [63:0] idx, logic lk, logic ft, logic os, logic cp,
                      logic pwe, logic [63:0] pwd, logic mwe, logic [63:0] mwd, string tag);
    logic [1:0]  f;
    logic [63:0] val;
    @(negedge clk);
    check_pending();
    req_valid = v; req_index = idx; req_lock = lk; feat_supported = ft;
    os_enable = os; inuse_cap = cp; prim_wr_en = pwe; prim_wr_data = pwd;
    map_wr_en = mwe; map_wr_data = mwd;
    f = ref_fault(idx, lk, ft, os, cp);
    val = ref_value(idx, mprim, mmap);
    e_done = v;
    e_fault = v ? f : 2'd0;
    f_tag = (f == 2'd1) ? "R7" : "R6";
    if (v && f == 2'd0) begin
      e_hi = {32'd0, val[63:32]};
      e_lo = {32'd0, val[31:0]};
      e_tag = (tag != "") ? tag : ((idx[31:0] == 0) ? "R4 R2" : "R5 R2");
    end else begin
      e_tag = (tag != "") ? tag : "R8";
    end
    // Model writes commit after the read (R12)
    if (pwe) mprim = pwd & MASK;
    if (mwe) mmap = mwd;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    mprim = 64'h1; mmap = '0;
    e_done = 1'b0; e_fault = 2'd0; e_hi = '0; e_lo = '0;
    e_tag = "R11"; f_tag = "R11";
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // Reset state (R11) checked by the first step
    step(1, 64'd0, 0, 1, 1, 1, 0, '0, 0, '0, "R11 primary");
    step(1, 64'd1, 0, 1, 1, 1, 0, '0, 0, '0, "R11 bitmap");
    // R10: all-ones write exposes mask
    step(0, 64'd0, 0, 1, 1, 1, 1, '1, 0, '0, "");
    step(1, 64'd0, 0, 1, 1, 1, 0, '0, 0, '0, "R10 mask");
    // R1: upper index bits ignored
    step(1, 64'hFFFF_FFFF_0000_0000, 0, 1, 1, 1, 0, '0, 0, '0, "R1 idx0");
    step(1, 64'hDEAD_BEEF_0000_0001, 0, 1, 1, 1, 0, '0, 1, 64'h0000_0002_0000_0201, "R1 idx1");
    step(1, 64'h0000_0001_0000_0001, 0, 1, 1, 1, 0, '0, 0, '0, "R1 R5");
    // R6 and R7 with held destinations (R8)
    step(1, 64'd1, 0, 1, 1, 0, 0, '0, 0, '0, "R8 gp cap0");
    step(1, 64'd2, 0, 1, 1, 1, 0, '0, 0, '0, "R8 gp idx2");
    step(1, 64'd7, 1, 1, 1, 1, 0, '0, 0, '0, "R8 ud over gp");
    step(1, 64'd0, 0, 0, 1, 1, 0, '0, 0, '0, "R8 ud feat");
    step(1, 64'd0, 0, 1, 0, 1, 0, '0, 0, '0, "R8 ud os");
    // R12: same-cycle writes do not affect the read
    step(1, 64'd1, 0, 1, 1, 1, 1, 64'h0000_0001_0000_00F0, 1, 64'hFFFF_FFFF_FFFF_FFFF, "R12 old");
    step(1, 64'd1, 0, 1, 1, 1, 0, '0, 0, '0, "R12 new");
    // Random traffic
    for (int i = 0; i < 3000; i++) begin
      logic [63:0] idx;
      int k;
      k = $urandom_range(0, 9);
      idx = {$urandom(), 32'd0};
      if (k < 4) idx[31:0] = 32'd0;
      else if (k < 8) idx[31:0] = 32'd1;
      else idx[31:0] = $urandom();
      step($urandom_range(0, 3) != 0, idx,
           $urandom_range(0, 9) == 0, $urandom_range(0, 9) != 0,
           $urandom_range(0, 9) != 0, $urandom_range(0, 3) != 0,
           $urandom_range(0, 4) == 0, {$urandom(), $urandom()},
           $urandom_range(0, 3) == 0, {$urandom(), $urandom()}, "");
    end
    step(0, '0, 0, 1, 1, 1, 0, '0, 0, '0, "");
    @(negedge clk);
    check_pending();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule